// File: doc/BRIEF.md
# Instruction Addressing-Type Analyzer

This unit classifies an instruction and does not execute it. When started, it reads the instruction word to be analyzed from memory, at a word address supplied on its start interface. That address is used directly. The unit decodes the 7-bit opcode into one of six operand addressing types. For memory-reference types it forms the effective word address. This can include one level of indirection through a pointer word and the addition of an index register. The unit then writes that address, rescaled to the operand granularity, into the destination register named by the instruction.

A 4-bit condition code reports the outcome. The upper three bits give the addressing type and the lowest bit repeats the instruction's indirect flag. Any refused memory access aborts the analysis with a one-cycle trap pulse. In that case no register is written and the condition code is not updated.

The analyzed word uses the following layout, from the MSB down: bit 31 is the indirect flag, bits 30:24 the opcode, bits 23:20 the destination register, bits 19:17 the index selector, and bits 16:0 the word address field.

Top module: `addr_type_analyzer`

## Requirements
- R1: A `start` pulse while idle issues a memory read at `ref_addr` exactly. The analyzed word is taken from that read, and the address is not modified.
- R2: The opcode (bits 30:24) selects the addressing type, and `cc[3:1]` reports it. Opcodes 0x60-0x7F are byte (000) and 0x40-0x5F are halfword (010). Opcodes 0x24-0x3F and 0x04-0x0F are word (100). Opcodes 0x20-0x23 are immediate word (101), 0x10-0x1F are doubleword (110), and 0x00-0x03 are immediate byte (001).
- R3: `cc[0]` equals bit 31 of the analyzed word: 0 for direct and 1 for indirect.
- R4: When the index selector (bits 19:17) is nonzero, the low 17 bits of the selected index register are added to the word address, modulo 2^17. When it is zero, no index is added, whatever index register 0 holds.
- R5: When bit 31 is set and the type is not immediate, one further read is made at the address field. The low 17 bits of the returned word become the base address.
- R6: The value written is the zero-extended effective word address. It is shifted left by 2 for byte, shifted left by 1 for halfword, left unchanged for word, and shifted right by 1 for doubleword.
- R7: For the immediate types, no register is written and no further memory access is made.
- R8: A read answered with `mem_err` raises `trap` for one cycle and ends the analysis. No register is written, `done` is not raised, and `cc` keeps its previous value.
- R9: `done` pulses for one cycle, exactly one cycle after the register write (or after decode for immediate types), and `cc` is valid from that cycle.
- R10: After reset, `busy`, `mem_req`, `rd_we`, `done` and `trap` are low and `cc` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an analysis (accepted while idle) |
| ref_addr | input | 17 | Word address of the instruction to analyze |
| busy | output | 1 | Analysis in progress |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | 17 | Read word address |
| mem_rvalid | input | 1 | Read answer valid |
| mem_err | input | 1 | Read refused (protection or nonexistent) |
| mem_rdata | input | 32 | Read data |
| idx_sel | output | 3 | Index register selector |
| idx_data | input | 32 | Selected index register contents |
| rd_we | output | 1 | Destination register write strobe |
| rd_idx | output | 4 | Destination register number |
| rd_data | output | 32 | Scaled displacement |
| cc | output | 4 | Condition code {type[2:0], indirect} |
| done | output | 1 | Analysis complete pulse |
| trap | output | 1 | Refused access pulse |

## Verification
A wrong decode state shows up in `cc[3:1]` in the `done` cycle, or as a write appearing or missing for an immediate opcode. This is visible within the same analysis. A stale base or index term shows up as a wrong `rd_data` in the single write cycle. A faulty sequencer is visible when `done` falls out of its one-cycle spacing after the write, or when a write slips through on a trapped analysis. It can also show as `cc` changing across a trap, which the next analysis's comparison exposes.

// File: rtl/ata_pkg.sv
package ata_pkg;

   typedef enum logic [2:0] {
      AT_BYTE = 3'b000,
      AT_IMMB = 3'b001,
      AT_HALF = 3'b010,
      AT_WORD = 3'b100,
      AT_IMMW = 3'b101,
      AT_DBL  = 3'b110
   } atype_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_DECODE,
      S_PTR,
      S_WRITE,
      S_DONE,
      S_TRAP
   } ata_state_e;

endpackage

// File: rtl/ata_opdecode.sv
module ata_opdecode
   import ata_pkg::*;
#(
   parameter int OPW = 7
) (
   input  logic [OPW-1:0] opcode,
   output atype_e         atype,
   output logic           immediate
);

   generate
      if (OPW != 7) begin : g_bad_opw
         $error("ata_opdecode: opcode field must be 7 bits");
      end
   endgenerate

   always_comb begin
      unique case (opcode[6:5])
         2'b11: atype = AT_BYTE;
         2'b10: atype = AT_HALF;
         2'b01: atype = (opcode[4:2] == 3'b000) ? AT_IMMW : AT_WORD;
         default: begin
            if (opcode[4])                    atype = AT_DBL;
            else if (opcode[3:2] == 2'b00)    atype = AT_IMMB;
            else                              atype = AT_WORD;
         end
      endcase
   end

   assign immediate = (atype == AT_IMMB) || (atype == AT_IMMW);

endmodule

// File: rtl/ata_disp_scale.sv
module ata_disp_scale
   import ata_pkg::*;
#(
   parameter int AW = 17,
   parameter int DW = 32
) (
   input  logic [AW-1:0] ea,
   input  atype_e        atype,
   output logic [DW-1:0] disp
);

   localparam int PADW = DW - AW;

   generate
      if (PADW < 2) begin : g_bad_width
         $error("ata_disp_scale: data width must exceed address width by 2");
      end
   endgenerate

   logic [DW-1:0] wide;
   assign wide = {{PADW{1'b0}}, ea};

   always_comb begin
      unique case (atype)
         AT_BYTE: disp = wide << 2;
         AT_HALF: disp = wide << 1;
         AT_DBL:  disp = wide >> 1;
         default: disp = wide;
      endcase
   end

endmodule

// File: rtl/addr_type_analyzer.sv
module addr_type_analyzer
   import ata_pkg::*;
#(
   parameter int DW  = 32,
   parameter int AW  = 17,
   parameter int XW  = 3,
   parameter int RW  = 4,
   parameter int OPW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] ref_addr,
   output logic          busy,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic          mem_err,
   input  logic [DW-1:0] mem_rdata,
   output logic [XW-1:0] idx_sel,
   input  logic [DW-1:0] idx_data,
   output logic          rd_we,
   output logic [RW-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   output logic [3:0]    cc,
   output logic          done,
   output logic          trap
);

   localparam int X_LO   = AW;
   localparam int R_LO   = AW + XW;
   localparam int OP_LO  = AW + XW + RW;
   localparam int IND_B  = OP_LO + OPW;
   localparam int LAYOUT = IND_B + 1;

   generate
      if (LAYOUT != DW) begin : g_bad_layout
         $error("addr_type_analyzer: instruction fields do not fill the word");
      end
   endgenerate

   ata_state_e    state_q;
   logic [DW-1:0] instr_q;
   logic [AW-1:0] ref_q;
   logic [AW-1:0] base_q;
   logic [3:0]    cc_q;

   logic [OPW-1:0] f_op;
   logic [XW-1:0]  f_x;
   logic [AW-1:0]  f_addr;
   logic           f_ind;
   atype_e         atype;
   logic           is_imm;
   logic [AW-1:0]  idx_term;
   logic [AW-1:0]  ea_sum;

   assign f_op   = instr_q[OP_LO +: OPW];
   assign f_x    = instr_q[X_LO +: XW];
   assign f_addr = instr_q[AW-1:0];
   assign f_ind  = instr_q[IND_B];

   ata_opdecode #(.OPW(OPW)) u_dec (
      .opcode    (f_op),
      .atype     (atype),
      .immediate (is_imm)
   );

   assign idx_term = (f_x != '0) ? idx_data[AW-1:0] : '0;
   assign ea_sum   = base_q + idx_term;

   ata_disp_scale #(.AW(AW), .DW(DW)) u_scale (
      .ea    (ea_sum),
      .atype (atype),
      .disp  (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         instr_q <= '0;
         ref_q   <= '0;
         base_q  <= '0;
         cc_q    <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: begin
               if (start) begin
                  ref_q   <= ref_addr;
                  state_q <= S_FETCH;
               end
            end
            S_FETCH: begin
               if (mem_rvalid) begin
                  if (mem_err) begin
                     state_q <= S_TRAP;
                  end else begin
                     instr_q <= mem_rdata;
                     state_q <= S_DECODE;
                  end
               end
            end
            S_DECODE: begin
               if (is_imm) begin
                  cc_q    <= {atype, f_ind};
                  state_q <= S_DONE;
               end else if (f_ind) begin
                  state_q <= S_PTR;
               end else begin
                  base_q  <= f_addr;
                  state_q <= S_WRITE;
               end
            end
            S_PTR: begin
               if (mem_rvalid) begin
                  if (mem_err) begin
                     state_q <= S_TRAP;
                  end else begin
                     base_q  <= mem_rdata[AW-1:0];
                     state_q <= S_WRITE;
                  end
               end
            end
            S_WRITE: begin
               cc_q    <= {atype, f_ind};
               state_q <= S_DONE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != S_IDLE);
   assign mem_req  = (state_q == S_FETCH) || (state_q == S_PTR);
   assign mem_addr = (state_q == S_FETCH) ? ref_q : f_addr;
   assign idx_sel  = f_x;
   assign rd_we    = (state_q == S_WRITE);
   assign rd_idx   = instr_q[R_LO +: RW];
   assign done     = (state_q == S_DONE);
   assign trap     = (state_q == S_TRAP);
   assign cc       = cc_q;

endmodule

// File: rtl/ata_checker.sv
module ata_checker #(
   parameter int AW = 17
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic [AW-1:0] ref_addr,
   input logic          mem_req,
   input logic [AW-1:0] mem_addr,
   input logic          mem_rvalid,
   input logic          rd_we,
   input logic [3:0]    cc,
   input logic          done,
   input logic          trap
);

   AST_FETCH_AT_REF: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (mem_req && mem_addr == $past(ref_addr)));  // R1

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));  // R5

   AST_IMM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cc[1]) |-> !$past(rd_we));  // R7

   AST_TRAP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> (!rd_we && !done));  // R8

   AST_TRAP_CC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      trap |=> $stable(cc));  // R8

   AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |=> done);  // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !rd_we && !done && !trap));  // R10

endmodule

bind addr_type_analyzer ata_checker #(.AW(AW)) u_ata_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .ref_addr   (ref_addr),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rvalid (mem_rvalid),
   .rd_we      (rd_we),
   .cc         (cc),
   .done       (done),
   .trap       (trap)
);

// File: tb/addr_type_analyzer_bench.sv
module addr_type_analyzer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int MEM_WORDS  = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [16:0] ref_addr = '0;
   logic        busy;
   logic        mem_req;
   logic [16:0] mem_addr;
   logic        mem_rvalid;
   logic        mem_err;
   logic [31:0] mem_rdata;
   logic [2:0]  idx_sel;
   logic [31:0] idx_data;
   logic        rd_we;
   logic [3:0]  rd_idx;
   logic [31:0] rd_data;
   logic [3:0]  cc;
   logic        done;
   logic        trap;

   always #(CLK_PERIOD/2) clk = ~clk;

   addr_type_analyzer u_addr_type_analyzer (
      .clk(clk), .rst_n(rst_n), .start(start), .ref_addr(ref_addr), .busy(busy),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_err(mem_err), .mem_rdata(mem_rdata), .idx_sel(idx_sel),
      .idx_data(idx_data), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
      .cc(cc), .done(done), .trap(trap)
   );

   logic [31:0] mem [MEM_WORDS];
   logic [31:0] xr  [8];

   assign idx_data = xr[idx_sel];

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rvalid <= 1'b0;
         mem_err    <= 1'b0;
         mem_rdata  <= '0;
      end else begin
         mem_rvalid <= mem_req && !mem_rvalid;
         mem_err    <= (mem_addr >= 17'(MEM_WORDS));
         mem_rdata  <= (mem_addr < 17'(MEM_WORDS)) ? mem[mem_addr[5:0]] : 32'h0;
      end
   end

   typedef struct {
      bit          is_trap;
      bit          wr;
      logic [3:0]  ridx;
      logic [31:0] rval;
      logic [3:0]  ccv;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   tests = 0;
   int   fails = 0;
   int   cyc = 0;
   int   wr_cyc = 0;
   bit   wrote = 1'b0;
   logic [3:0] last_cc = 4'b0000;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] mk(input logic ind, input logic [6:0] op,
                                      input logic [3:0] r, input logic [2:0] x,
                                      input logic [16:0] a);
      return {ind, op, r, x, a};
   endfunction

   function automatic logic [2:0] type_of(input logic [6:0] op);
      if (op >= 7'h60)      return 3'b000;
      else if (op >= 7'h40) return 3'b010;
      else if (op >= 7'h24) return 3'b100;
      else if (op >= 7'h20) return 3'b101;
      else if (op >= 7'h10) return 3'b110;
      else if (op >= 7'h04) return 3'b100;
      else                  return 3'b001;
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] expv);
      tests++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   // Monitor: pops expected items as results appear at the ports
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_we) begin
            if (exp_q.size() == 0 || !exp_q[0].wr || exp_q[0].is_trap) begin
               check("R7 unexpected write", {28'h0, rd_idx}, 32'hFFFFFFFF);
            end else begin
               check({"R6 reg ", exp_q[0].tag}, {28'h0, rd_idx}, {28'h0, exp_q[0].ridx});
               check({"R4 R5 R6 value ", exp_q[0].tag}, rd_data, exp_q[0].rval);
            end
            wrote  = 1'b1;
            wr_cyc = cyc;
         end
         if (done) begin
            if (exp_q.size() == 0 || exp_q[0].is_trap) begin
               check("R9 unexpected done", 32'h1, 32'h0);
            end else begin
               check({"R2 R3 cc ", exp_q[0].tag}, {28'h0, cc}, {28'h0, exp_q[0].ccv});
               check({"R7 write presence ", exp_q[0].tag}, {31'h0, wrote}, {31'h0, exp_q[0].wr});
               if (wrote) check({"R9 done spacing ", exp_q[0].tag}, cyc - wr_cyc, 32'd1);
               void'(exp_q.pop_front());
            end
            wrote = 1'b0;
         end
         if (trap) begin
            if (exp_q.size() == 0 || !exp_q[0].is_trap) begin
               check("R8 unexpected trap", 32'h1, 32'h0);
            end else begin
               check({"R8 no write ", exp_q[0].tag}, {31'h0, wrote}, 32'h0);
               check({"R8 cc kept ", exp_q[0].tag}, {28'h0, cc}, {28'h0, exp_q[0].ccv});
               void'(exp_q.pop_front());
            end
            wrote = 1'b0;
         end
      end
   end

   // Driver: computes the expected outcome and starts one analysis
   task automatic analyze(input logic [16:0] ra, input string tag);
      exp_t        e;
      logic [31:0] w;
      logic [2:0]  ty;
      logic [16:0] base, ea;
      w = (ra < 17'(MEM_WORDS)) ? mem[ra[5:0]] : 32'h0;
      ty = type_of(w[30:24]);
      e.tag = tag; e.is_trap = 1'b0; e.wr = 1'b0;
      e.ridx = w[23:20]; e.rval = '0; e.ccv = {ty, w[31]};
      if (ra >= 17'(MEM_WORDS)) begin
         e.is_trap = 1'b1;
      end else if (ty == 3'b001 || ty == 3'b101) begin
         e.wr = 1'b0;
      end else begin
         base = w[16:0];
         if (w[31]) begin
            if (w[16:0] >= 17'(MEM_WORDS)) e.is_trap = 1'b1;
            else base = mem[w[5:0]][16:0];
         end
         ea = base + ((w[19:17] != 3'd0) ? xr[w[19:17]][16:0] : 17'd0);
         e.wr = 1'b1;
         case (ty)
            3'b000:  e.rval = {15'h0, ea} * 4;
            3'b010:  e.rval = {15'h0, ea} * 2;
            3'b110:  e.rval = {15'h0, ea} / 2;
            default: e.rval = {15'h0, ea};
         endcase
      end
      if (e.is_trap) begin
         e.wr = 1'b0;
         e.ccv = last_cc;
      end else begin
         last_cc = e.ccv;
      end
      exp_q.push_back(e);
      @(negedge clk);
      ref_addr = ra;
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
      for (int k = 0; k < 50 && exp_q.size() != 0; k++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0;
      for (int i = 0; i < 8; i++) xr[i] = 32'h0;
      xr[0] = 32'd99;
      xr[1] = 32'd2;
      xr[3] = 32'd7;
      xr[5] = 32'hFFFF_FFFF;
      mem[2]  = mk(1'b0, 7'h08, 4'd1, 3'd0, 17'd5);
      mem[3]  = mk(1'b0, 7'h70, 4'd2, 3'd3, 17'd10);
      mem[4]  = mk(1'b1, 7'h40, 4'd3, 3'd0, 17'd12);
      mem[12] = 32'hABC0_1234;
      mem[5]  = mk(1'b0, 7'h10, 4'd4, 3'd0, 17'h1FFFF);
      mem[6]  = mk(1'b0, 7'h01, 4'd5, 3'd0, 17'd0);
      mem[7]  = mk(1'b1, 7'h21, 4'd6, 3'd2, 17'd9);
      mem[8]  = mk(1'b1, 7'h0C, 4'd7, 3'd0, 17'd200);
      mem[9]  = mk(1'b0, 7'h50, 4'd8, 3'd0, 17'd40);
      mem[10] = mk(1'b0, 7'h30, 4'd9, 3'd5, 17'd3);
      mem[11] = mk(1'b0, 7'h7F, 4'd10, 3'd0, 17'h1FFFF);
      mem[13] = mk(1'b1, 7'h18, 4'd11, 3'd1, 17'd20);
      mem[20] = 32'h0000_0100;

      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 busy",    {31'h0, busy},    32'h0);
      check("R10 mem_req", {31'h0, mem_req}, 32'h0);
      check("R10 outputs", {29'h0, rd_we, done, trap}, 32'h0);
      check("R10 cc",      {28'h0, cc},      32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      analyze(17'd2,  "R1 word direct");
      analyze(17'd3,  "R4 byte indexed");
      analyze(17'd4,  "R5 halfword indirect");
      analyze(17'd5,  "R6 doubleword max");
      analyze(17'd6,  "R7 immediate byte");
      analyze(17'd7,  "R7 immediate word indirect");
      analyze(17'd100, "R8 trap on fetch");
      analyze(17'd8,  "R8 trap on pointer");
      analyze(17'd9,  "R4 zero selector");
      analyze(17'd10, "R4 index wrap");
      analyze(17'd11, "R6 byte max");
      analyze(17'd13, "R5 indirect plus index");

      check("R9 all results seen", exp_q.size(), 32'd0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule